// File: doc/BRIEF.md
# Hash Message Padding Unit

This unit sits in front of a SHA-256 compression engine. It takes a message as a stream of 32-bit words and produces the padded message that the engine consumes: a sequence of 512-bit blocks, each sent as sixteen 32-bit words. The last message word may be partial. A 2-bit valid-bytes field says how many of its bytes belong to the message. The unit keeps a 64-bit running count of message bits. After the data it appends a single one bit, zero fill, and the bit count in the final two words of the last block. When the one bit and the count do not both fit in the current block, it adds one more block.

Both sides are valid/ready streams. An input word moves when `in_valid` and `in_ready` are high at the same clock edge. An output word moves when `out_valid` and `out_ready` are high at the same edge. The producer may drop `in_valid` at any time to insert wait states. The consumer may drop `out_ready` at any time. While the output is held, the output word and its flags stay frozen, and `in_ready` goes low in the same cycle, so an output stall closes the input window. `start` is a plain control pulse that aborts any message in progress and opens a new one. `error` is a plain sticky status pin.

Top module: `sha_pad_unit`

## Requirements
- R1: After reset, `in_ready`, `out_valid` and `error` are all low.
- R2: After a `start` pulse, each accepted input word is emitted unchanged and in order, at most one word per clock. Every 16th output word of the padded stream carries `out_last_word`.
- R3: A low `in_valid` or a low `out_ready` loses and duplicates no data. While `out_valid` is high and `out_ready` is low, the output word and its flags are held, and `in_ready` is low.
- R4: `in_bytes` on the end word gives its valid bytes: 00 = four, 01 = one, 10 = two, 11 = three. Valid bytes take the most significant lanes (big-endian). A partial end word keeps its valid bytes, has 0x80 in the next lane, and has zero in all lower lanes.
- R5: When the end word is a full word, the next output word is 0x80000000. Every word between the one bit and the length is zero.
- R6: The message length in bits (32 per full word, 8 per valid byte of the end word) is sent as a 64-bit value. Its upper half goes in word 14 and its lower half in word 15 of the final block. `out_last_block` is high only on that word 15.
- R7: When the one bit lands in word 14 or 15 of a block, that block is finished with zeros. One more block follows, which is zero except for the length.
- R8: After the end word is accepted, `in_ready` stays low until the next `start`. Words offered in that time are ignored and raise no error.
- R9: A written word that is not marked as the end word, with a non-zero `in_bytes`, sets `error`. `error` stays set until the next `start`.
- R10: `in_valid` high while no message is open (after reset, before the first `start`) sets `error`.
- R11: `start` in the middle of a message discards the message and any pending output word, clears `error`, and begins a new message from word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a new message (aborts any current one) |
| in_valid | input | 1 | Input word write strobe |
| in_ready | output | 1 | Input window open and output slot free |
| in_data | input | 32 | Message word, big-endian bytes |
| in_end | input | 1 | Marks the final message word |
| in_bytes | input | 2 | Valid bytes of the word (00 = all four) |
| out_valid | output | 1 | Padded word available |
| out_ready | input | 1 | Consumer accepts the output word |
| out_data | output | 32 | Padded message word |
| out_last_word | output | 1 | Word is position 15 of its block |
| out_last_block | output | 1 | Word ends the padded message |
| error | output | 1 | Sticky protocol error flag |

## Verification
Assertions check on every cycle the stream rules: a held output word and its flags stay stable, `in_ready` drops while the output is stalled, the input window stays closed after the end word, the error flag stays set, the last-block flag appears only on a last-word position, and the bit count stays byte-aligned. The content of the padded stream can only be shown by the bench scenarios. These are the one-bit placement, zero fill, the length words, the choice to add an extra block, and the formatting of every end-word byte count. The bench sweeps message lengths across one and two block boundaries with all four byte counts, with and without stalls on both sides, and compares every word against padding computed byte by byte. The error and abort rules are shown only by directed scenarios.

// File: rtl/sha_pad_pkg.sv
package sha_pad_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_PAD  = 2'd2,
    ST_DONE = 2'd3
  } pad_state_e;

endpackage

// File: rtl/sha_pad_bitcnt.sv
module sha_pad_bitcnt #(
  parameter int LEN_W  = 64,
  parameter int LANES  = 4,
  parameter int SEL_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             add_en,
  input  logic [SEL_W-1:0] sel,
  output logic [LEN_W-1:0] count
);

  localparam int FULL_BITS = LANES * 8;

  logic [LEN_W-1:0] inc;

  always_comb begin
    if (sel == '0) inc = LEN_W'(FULL_BITS);
    else           inc = LEN_W'(sel) << 3;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  count <= '0;
    else if (add_en) count <= count + inc;
  end

  // R6: the length is built from whole bytes only
  assert_byte_aligned_R6: assert property (@(posedge clk) disable iff (rst)
    count[2:0] == 3'd0);

endmodule

// File: rtl/sha_pad_lanes.sv
module sha_pad_lanes #(
  parameter int WORD_W = 32,
  parameter int SEL_W  = 2
) (
  input  logic [WORD_W-1:0] din,
  input  logic [SEL_W-1:0]  sel,
  input  logic              is_end,
  output logic [WORD_W-1:0] dout
);

  localparam int LANES = WORD_W / 8;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [SEL_W:0] LANE_IX = (SEL_W+1)'(i);
    logic [SEL_W:0] nvalid;
    logic           keep;
    logic           marker;

    assign nvalid = (sel == '0) ? (SEL_W+1)'(LANES) : {1'b0, sel};
    assign keep   = !is_end || (LANE_IX < nvalid);
    assign marker = is_end && (sel != '0) && (LANE_IX == nvalid);

    assign dout[WORD_W-1-8*i -: 8] = keep   ? din[WORD_W-1-8*i -: 8] :
                                     marker ? 8'h80 : 8'h00;
  end

endmodule

// File: rtl/sha_pad_oreg.sv
module sha_pad_oreg #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              ld,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              ld_last_word,
  input  logic              ld_last_block,
  input  logic              ready,
  output logic              valid,
  output logic [WORD_W-1:0] data,
  output logic              last_word,
  output logic              last_block
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      valid      <= 1'b0;
      data       <= '0;
      last_word  <= 1'b0;
      last_block <= 1'b0;
    end else if (ld) begin
      valid      <= 1'b1;
      data       <= ld_data;
      last_word  <= ld_last_word;
      last_block <= ld_last_block;
    end else if (ready) begin
      valid      <= 1'b0;
    end
  end

  // R3: a stalled word and its flags are held
  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready && !clr) |=> (valid && $stable(data) &&
                                   $stable(last_word) && $stable(last_block)));

endmodule

// File: rtl/sha_pad_unit.sv
module sha_pad_unit
  import sha_pad_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int LEN_W     = 64,
  parameter int BLK_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_end,
  input  logic [1:0]        in_bytes,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last_word,
  output logic              out_last_block,
  output logic              error
);

  localparam int LANES = WORD_W / 8;
  localparam int SEL_W = $clog2(LANES);
  localparam int CNT_W = $clog2(BLK_WORDS);
  localparam logic [CNT_W-1:0] POS_HI = CNT_W'(BLK_WORDS - 2);
  localparam logic [CNT_W-1:0] POS_LO = CNT_W'(BLK_WORDS - 1);
  localparam logic [WORD_W-1:0] ONE_WORD = {1'b1, {(WORD_W-1){1'b0}}};

  pad_state_e       state;
  logic [CNT_W-1:0] wpos;
  logic             one_pend;
  logic             spill;
  logic             err_q;

  logic             slot_free;
  logic             in_acc;
  logic             pad_emit;
  logic [LEN_W-1:0] bitcnt;
  logic [WORD_W-1:0] fmt_word;
  logic [WORD_W-1:0] pad_word;
  logic             pad_is_len_lo;
  logic             ld;
  logic [WORD_W-1:0] ld_data;
  logic             ld_last_block;

  assign slot_free = !out_valid || out_ready;
  assign in_ready  = (state == ST_DATA) && slot_free && !start;
  assign in_acc    = in_valid && in_ready;
  assign pad_emit  = (state == ST_PAD) && slot_free && !start;

  sha_pad_lanes #(.WORD_W(WORD_W), .SEL_W(SEL_W)) u_lanes (
    .din    (in_data),
    .sel    (in_bytes[SEL_W-1:0]),
    .is_end (in_end),
    .dout   (fmt_word)
  );

  sha_pad_bitcnt #(.LEN_W(LEN_W), .LANES(LANES), .SEL_W(SEL_W)) u_bitcnt (
    .clk    (clk),
    .rst    (rst),
    .clr    (start),
    .add_en (in_acc),
    .sel    (in_bytes[SEL_W-1:0]),
    .count  (bitcnt)
  );

  always_comb begin
    pad_word      = '0;
    pad_is_len_lo = 1'b0;
    if (one_pend) begin
      pad_word = ONE_WORD;
    end else if (!spill && wpos == POS_HI) begin
      pad_word = bitcnt[LEN_W-1 -: WORD_W];
    end else if (!spill && wpos == POS_LO) begin
      pad_word      = bitcnt[WORD_W-1:0];
      pad_is_len_lo = 1'b1;
    end
  end

  assign ld            = in_acc || pad_emit;
  assign ld_data       = in_acc ? fmt_word : pad_word;
  assign ld_last_block = pad_emit && pad_is_len_lo;

  sha_pad_oreg #(.WORD_W(WORD_W)) u_oreg (
    .clk           (clk),
    .rst           (rst),
    .clr           (start),
    .ld            (ld),
    .ld_data       (ld_data),
    .ld_last_word  (wpos == POS_LO),
    .ld_last_block (ld_last_block),
    .ready         (out_ready),
    .valid         (out_valid),
    .data          (out_data),
    .last_word     (out_last_word),
    .last_block    (out_last_block)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      wpos     <= '0;
      one_pend <= 1'b0;
      spill    <= 1'b0;
      err_q    <= 1'b0;
    end else if (start) begin
      state    <= ST_DATA;
      wpos     <= '0;
      one_pend <= 1'b0;
      spill    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if ((state == ST_IDLE && in_valid) ||
          (in_acc && !in_end && in_bytes != 2'b00))
        err_q <= 1'b1;
      if (in_acc) begin
        wpos <= wpos + 1'b1;
        if (in_end) begin
          state    <= ST_PAD;
          one_pend <= (in_bytes == 2'b00);
          spill    <= (in_bytes != 2'b00) && (wpos == POS_HI);
        end
      end else if (pad_emit) begin
        wpos <= wpos + 1'b1;
        if (one_pend) begin
          one_pend <= 1'b0;
          spill    <= (wpos == POS_HI);
        end else if (wpos == POS_LO) begin
          spill <= 1'b0;
          if (!spill) state <= ST_DONE;
        end
      end
    end
  end

  assign error = err_q;

  // R3: an output stall closes the input window in the same cycle
  assert_stall_closes_input_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R8: no input is taken after the end word until a new start
  assert_closed_after_end_R8: assert property (@(posedge clk) disable iff (rst)
    (in_acc && in_end && !start) |=> !in_ready);

  // R9: the error flag is sticky
  assert_error_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (error && !start) |=> error);

  // R6: last-block marker only on the final word of a block
  assert_last_block_pos_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last_block) |-> out_last_word);

endmodule

// File: tb/sha_pad_unit_test.sv
module sha_pad_unit_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_data;
  logic        in_end;
  logic [1:0]  in_bytes;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_data;
  logic        out_last_word;
  logic        out_last_block;
  logic        error;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  sha_pad_unit uut (
    .clk(clk), .rst(rst), .start(start),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_end(in_end), .in_bytes(in_bytes),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last_word(out_last_word), .out_last_block(out_last_block),
    .error(error)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d expected<=190000 cycles", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] msg_word(input int c, input int j);
    return {8'(c * 7 + 1), 8'(j), 8'(j * 3 + c), 8'hC3 ^ 8'(j + c)};
  endfunction

  // byte k of the padded stream, computed from the message bytes
  function automatic logic [7:0] exp_byte(input int c, input int n, input int total,
                                          input int k);
    logic [31:0] w;
    logic [63:0] len;
    len = 64'(n) * 64'd8;
    if (k < n) begin
      w = msg_word(c, k / 4);
      return w[31 - 8*(k%4) -: 8];
    end
    if (k == n) return 8'h80;
    if (k >= total - 8) return len[63 - 8*(k - (total - 8)) -: 8];
    return 8'h00;
  endfunction

  task automatic pulse_start();
    @(posedge clk); #1;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic run_case(input int c, input int nw, input logic [1:0] sel,
                          input bit stall);
    int n, total, nexp, widx, oidx, cyc;
    bit acc;
    logic [31:0] ew;
    string tag;
    n = 4 * (nw - 1) + ((sel == 2'b00) ? 4 : int'(sel));
    total = ((n + 8) / 64 + 1) * 64;
    nexp = total / 4;
    widx = 0; oidx = 0; cyc = 0;
    pulse_start();
    while (oidx < nexp && cyc < 3000) begin
      if (widx < nw) begin
        in_valid = stall ? ((cyc % 5) != 2) : 1'b1;
        in_data  = msg_word(c, widx);
        in_end   = (widx == nw - 1);
        in_bytes = (widx == nw - 1) ? sel : 2'b00;
      end else begin
        in_valid = ((cyc % 3) == 0);
        in_data  = 32'hDEAD0000 + 32'(cyc);
        in_end   = 1'b0;
        in_bytes = 2'b01;
      end
      out_ready = stall ? ((cyc % 4) != 1) : 1'b1;
      @(negedge clk);
      acc = in_valid && in_ready;
      if (out_valid && out_ready) begin
        ew = {exp_byte(c, n, total, 4*oidx), exp_byte(c, n, total, 4*oidx+1),
              exp_byte(c, n, total, 4*oidx+2), exp_byte(c, n, total, 4*oidx+3)};
        if (4*oidx + 3 < n)            tag = "R2 data word";
        else if (4*oidx <= n && n < 4*oidx + 4)
          tag = (sel == 2'b00) ? "R5 one-bit word" : "R4 end-word format";
        else if (4*oidx >= total - 8)  tag = "R6 length word";
        else if (total - n > 64)       tag = "R7 extra-block fill";
        else                           tag = "R5 zero fill";
        chk(out_data === ew, tag, 64'(out_data), 64'(ew));
        chk({out_last_word, out_last_block} ===
              {(oidx % 16) == 15, oidx == nexp - 1},
            "R2 R6 block flags", 64'({out_last_word, out_last_block}),
            64'({(oidx % 16) == 15, oidx == nexp - 1}));
        oidx++;
      end
      @(posedge clk); #1;
      if (acc) widx++;
      cyc++;
    end
    chk(oidx == nexp, "R3 output word count", 64'(oidx), 64'(nexp));
    chk(widx == nw, "R3 input words taken", 64'(widx), 64'(nw));
    in_valid = 1'b1; in_bytes = 2'b10; out_ready = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b0, "R8 window closed after end", 64'(in_ready), 64'd0);
    chk(error === 1'b0, "R8 late words ignored", 64'(error), 64'd0);
    chk(out_valid === 1'b0, "R2 no extra output", 64'(out_valid), 64'd0);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; in_valid = 1'b0; in_data = '0;
    in_end = 1'b0; in_bytes = 2'b00; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready === 1'b0, "R1 reset in_ready", 64'(in_ready), 64'd0);
    chk(out_valid === 1'b0, "R1 reset out_valid", 64'(out_valid), 64'd0);
    chk(error === 1'b0, "R1 reset error", 64'(error), 64'd0);

    // R10: strobe with no message open
    @(posedge clk); #1;
    in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    chk(error === 1'b1, "R10 strobe before start", 64'(error), 64'd1);

    // main sweep: lengths across one and two block boundaries, all byte counts
    for (int nw = 1; nw <= 33; nw++) begin
      for (int s = 0; s < 4; s++) begin
        run_case(nw * 4 + s, nw, 2'(s), ((nw + s) % 2) == 1);
      end
    end

    // R9: non-zero byte count on a non-end word
    pulse_start();
    out_ready = 1'b1;
    in_valid = 1'b1; in_data = 32'h01020304; in_end = 1'b0; in_bytes = 2'b10;
    @(posedge clk); #1;
    in_valid = 1'b0; in_bytes = 2'b00;
    @(negedge clk);
    chk(error === 1'b1, "R9 byte count on non-end word", 64'(error), 64'd1);
    repeat (5) @(posedge clk);
    #1;
    @(negedge clk);
    chk(error === 1'b1, "R9 error sticky", 64'(error), 64'd1);

    // R11: abort mid-message with a pending output word, then a fresh message
    pulse_start();
    out_ready = 1'b0;
    in_valid = 1'b1; in_end = 1'b0; in_bytes = 2'b11; in_data = 32'hBADBAD00;
    repeat (3) @(posedge clk);
    #1;
    in_valid = 1'b0;
    @(negedge clk);
    chk(error === 1'b1, "R11 error before abort", 64'(error), 64'd1);
    chk(out_valid === 1'b1, "R11 pending word before abort", 64'(out_valid), 64'd1);
    @(posedge clk); #1;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    chk(error === 1'b0, "R11 error cleared by start", 64'(error), 64'd0);
    chk(out_valid === 1'b0, "R11 pending word dropped", 64'(out_valid), 64'd0);
    run_case(200, 2, 2'b01, 1'b1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule